// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This is a single-port synchronous SRAM built so that reads and writes can follow one another on consecutive clocks without idle bus cycles. The address and control inputs are registered on a rising clock edge. The data for that operation uses a shared bidirectional bus and is tied to the second enabled edge after the address. For a read, the device drives the data during the cycle that ends on that edge. For a write, the device samples the data on that edge. Because writes are delayed by the same two stages as reads, a controller can switch between reads and writes on any cycle.

Each operation carries its type, byte-lane enables and address through a two-stage pipeline. A write updates the array on the edge where its data is on the bus. A read that overlaps a write not yet committed receives that write's data, merged lane by lane with the array. A burst counter continues a four-word sequence from the last loaded address, in either linear or interleaved order. A freeze input stalls the whole block. An asynchronous output enable can release the bus at any moment.

Top module: `zt_sram`

## Requirements
- R1: A read issued on enabled edge k (`burst_go`=0, `is_read`=1, block selected) drives the stored word on `data_io` between enabled edges k+1 and k+2.
- R2: A write issued on enabled edge k (`is_read`=0) stores the `data_io` value present at enabled edge k+2. A later read returns that value.
- R3: `lane_we_n` is sampled with the address. Bit i, when 0, enables 9-bit lane i (bits 9i+8..9i) for a write. Lanes whose bit is 1 keep their previous contents.
- R4: A new operation starts only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 while `burst_go`=0. Any other chip-select combination with `burst_go`=0 is a deselect, and the bus stays undriven in its data cycle. An advance (`burst_go`=1) after a deselect is also a deselect.
- R5: While `freeze`=1, all synchronous inputs are ignored and every register holds its value. A pending read keeps its data on the bus, and the two-cycle count pauses.
- R6: `out_en_n`=1 releases `data_io` immediately, without waiting for a clock edge. Returning it to 0 restores the pending read data.
- R7: With `seq_linear`=1, each advance (`burst_go`=1) after a load continues the same operation type. The address is formed from the loaded address, with its two low bits increased by the step count modulo 4.
- R8: With `seq_linear`=0, an advance uses the loaded address with its two low bits XORed with the step count (1, 2, 3, 0, ...).
- R9: A read issued one enabled edge after a write to the same address returns the write's data in its enabled lanes and the older contents in the others.
- R10: The device never drives `data_io` during a write's data cycle. Reads and writes may alternate on every enabled edge.
- R11: After reset, no operation or burst is active and `data_io` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| freeze | input | 1 | 1 suspends the block; all registers hold |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_go | input | 1 | 1 advances the burst, 0 loads a new address |
| is_read | input | 1 | 1 read, 0 write; sampled on a load |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| data_io | inout | LANES*LANE_W | Shared data bus |

## Verification
The bench builds the block with its default parameters: four 9-bit lanes and a 6-bit address. The 36-bit words are wide enough to show a lane merge in both directions. With 64 words, the bench can use separate address rows for the plain, linear-burst and interleaved-burst tests, so results from one test cannot mask another. Two-bit burst offsets inside a small row let the bench reach every wrap of both burst orders, starting from non-zero offsets.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             burst_go,
  input  logic             is_read,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             seq_linear,
  input  logic             out_en_n,
  input  logic [AW-1:0]    addr,
  inout  wire  [LANES*LANE_W-1:0] data_io
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic             p1_v, p1_rd, p2_v, p2_rd, b_act, b_rd;
  logic [AW-1:0]    p1_a, p2_a, b_base;
  logic [LANES-1:0] p1_be, p2_be;
  logic [1:0]       b_cnt;
  logic [DW-1:0]    dout_q, rd_word;

  wire       go   = !freeze;
  wire       sel  = !sel_a_n && sel_b && !sel_c_n;
  wire       load = !burst_go;
  wire [1:0] step = b_cnt + 2'd1;
  wire [1:0] lo   = seq_linear ? b_base[1:0] + step : b_base[1:0] ^ step;

  wire          i_v  = load ? sel : b_act;
  wire          i_rd = load ? is_read : b_rd;
  wire [AW-1:0] i_a  = load ? addr : {b_base[AW-1:2], lo};

  wire wr_now = p2_v && !p2_rd;

  always_comb begin
    rd_word = mem[p1_a];
    if (wr_now && p2_a == p1_a)
      for (int i = 0; i < LANES; i++)
        if (p2_be[i]) rd_word[i*LANE_W +: LANE_W] = data_io[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v <= 1'b0; p1_rd <= 1'b0; p1_a <= '0; p1_be <= '0;
      p2_v <= 1'b0; p2_rd <= 1'b0; p2_a <= '0; p2_be <= '0;
      b_act <= 1'b0; b_rd <= 1'b0; b_base <= '0; b_cnt <= '0;
      dout_q <= '0;
    end else if (go) begin
      p1_v  <= i_v;
      p1_rd <= i_rd;
      p1_a  <= i_a;
      p1_be <= ~lane_we_n;
      p2_v  <= p1_v;
      p2_rd <= p1_rd;
      p2_a  <= p1_a;
      p2_be <= p1_be;
      if (p1_v && p1_rd) dout_q <= rd_word;
      if (load) begin
        b_act <= sel;
        if (sel) begin
          b_base <= addr;
          b_rd   <= is_read;
          b_cnt  <= 2'd0;
        end
      end else if (b_act) begin
        b_cnt <= step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go && wr_now)
      for (int i = 0; i < LANES; i++)
        if (p2_be[i]) mem[p2_a][i*LANE_W +: LANE_W] <= data_io[i*LANE_W +: LANE_W];
  end

  assign data_io = (p2_v && p2_rd && !out_en_n) ? dout_q : {DW{1'bz}};

  p_read_to_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && load && sel && is_read) ##1 go |=> (p2_v && p2_rd));

  p_write_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wr_now && (&p2_be)) |=> (mem[$past(p2_a)] == $past(data_io)));

  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && load && !sel) ##1 go |=> !p2_v);

  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(p1_v) && $stable(p2_v) && $stable(dout_q) && $stable(b_cnt) && $stable(p2_a)));

  p_burst_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !load && b_act) |=> (p1_v && p1_a[AW-1:2] == $past(b_base[AW-1:2])));
endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 4;
  localparam int LW = 9;
  localparam int AW = 6;
  localparam int DW = L * LW;

  logic clk = 0, rst_n = 0, freeze = 1;
  logic sel_a_n = 1, sel_b = 0, sel_c_n = 1, burst_go = 0, is_read = 1;
  logic seq_linear = 1, out_en_n = 0;
  logic [L-1:0]  lane_we_n = '1;
  logic [AW-1:0] addr = '0;
  wire  [DW-1:0] data_io;

  logic ten = 0, pen = 0;
  logic [DW-1:0] tdq = '0, probe = '0;
  assign data_io = ten ? tdq : (pen ? probe : {DW{1'bz}});

  zt_sram #(.LANES(L), .LANE_W(LW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .burst_go(burst_go), .is_read(is_read), .lane_we_n(lane_we_n),
    .seq_linear(seq_linear), .out_en_n(out_en_n), .addr(addr), .data_io(data_io));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {int at; logic [DW-1:0] d; bit quiet; string tag;} item_t;
  item_t chkq[$];
  item_t wq[$];
  logic [DW-1:0] model [1<<AW];
  int ecnt = 0, checks = 0, errors = 0;
  bit bact = 0, brw = 0, done = 0;
  logic [AW-1:0] bbase = '0;
  int bn = 0;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int n);
    return DW'(n) * 36'h1_0F1E_2D3D + 36'h3_3C4B_5A69;
  endfunction

  always @(posedge clk) begin
    bit en;
    string tg;
    en = rst_n && !freeze;
    if (en) begin
      while (chkq.size() != 0 && chkq[0].at <= ecnt) void'(chkq.pop_front());
      ecnt++;
      if (wq.size() != 0 && wq[0].at == ecnt) begin
        tdq <= wq[0].d;
        ten <= 1'b1;
        void'(wq.pop_front());
      end else ten <= 1'b0;
    end
    if (chkq.size() != 0 && chkq[0].at == ecnt) begin
      tg = en ? chkq[0].tag : {"R5/", chkq[0].tag};
      if (chkq[0].quiet) begin
        probe = pat(ecnt + 100);
        pen = 1'b1;
        #2;
        chk(data_io === probe, tg, data_io, probe);
        pen = 1'b0;
      end else begin
        #2;
        chk(data_io === chkq[0].d, tg, data_io, chkq[0].d);
      end
    end
  end

  task automatic issue(input bit adv, input bit c1n, input bit c2, input bit c3n, input bit rwv,
                       input logic [AW-1:0] a, input logic [L-1:0] bwn, input logic [DW-1:0] d,
                       input string tag);
    bit v, r;
    logic [AW-1:0] ea;
    item_t it;
    @(negedge clk);
    freeze = 0; burst_go = adv; sel_a_n = c1n; sel_b = c2; sel_c_n = c3n;
    is_read = rwv; addr = a; lane_we_n = bwn;
    if (!adv) begin
      v = !c1n && c2 && !c3n; r = rwv; ea = a; bact = v;
      if (v) begin bbase = a; bn = 0; brw = rwv; end
    end else begin
      v = bact; r = brw;
      if (bact) bn = (bn + 1) % 4;
      ea = seq_linear ? {bbase[AW-1:2], 2'(bbase[1:0] + 2'(bn))}
                      : {bbase[AW-1:2], bbase[1:0] ^ 2'(bn)};
    end
    it.at = ecnt + 2;
    it.tag = tag;
    if (!v) begin
      it.quiet = 1; it.d = '0;
    end else if (r) begin
      it.quiet = 0; it.d = model[ea];
    end else begin
      for (int i = 0; i < L; i++)
        if (!bwn[i]) model[ea][i*LW +: LW] = d[i*LW +: LW];
      it.quiet = 0; it.d = d;
      wq.push_back(it);
    end
    chkq.push_back(it);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [L-1:0] bwn, input logic [DW-1:0] d, input string tag);
    issue(0, 0, 1, 0, 0, a, bwn, d, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    issue(0, 0, 1, 0, 1, a, '1, '0, tag);
  endtask

  task automatic idle(input string tag);
    issue(0, 1, 0, 1, 1, '0, '1, '0, tag);
  endtask

  task automatic hold();
    @(negedge clk);
    freeze = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0; burst_go = 0; is_read = 0;
    addr = 6'h3F; lane_we_n = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    probe = pat(7); pen = 1; #1;
    chk(data_io === probe, "R11", data_io, probe);
    pen = 0;

    idle("R11");
    for (int i = 0; i < 4; i++) wr(AW'(6'h10 + i), 4'h0, pat(i), "R2/R10");
    for (int i = 0; i < 4; i++) rd(AW'(6'h10 + i), "R1");

    wr(6'h18, 4'h0, pat(10), "R10");
    rd(6'h11, "R10");
    wr(6'h19, 4'h0, pat(11), "R10");
    rd(6'h18, "R10");
    wr(6'h20, 4'h0, pat(20), "R9");
    rd(6'h20, "R9");

    wr(6'h10, 4'b1010, pat(30), "R3");
    rd(6'h10, "R3/R9");
    idle("R4");
    rd(6'h10, "R3");

    issue(0, 1, 1, 0, 1, 6'h11, '1, '0, "R4");
    issue(0, 0, 0, 0, 1, 6'h11, '1, '0, "R4");
    issue(0, 0, 1, 1, 1, 6'h11, '1, '0, "R4");
    issue(1, 0, 1, 0, 1, 6'h11, '1, '0, "R4");

    seq_linear = 1;
    wr(6'h21, 4'h0, pat(40), "R7");
    for (int i = 1; i < 4; i++) issue(1, 1, 0, 1, 1, '0, 4'h0, pat(40 + i), "R7");
    rd(6'h21, "R7");
    for (int i = 0; i < 4; i++) issue(1, 1, 0, 1, 0, '0, '1, '0, "R7");

    seq_linear = 0;
    wr(6'h35, 4'h0, pat(50), "R8");
    for (int i = 1; i < 4; i++) issue(1, 1, 0, 1, 1, '0, 4'h0, pat(50 + i), "R8");
    rd(6'h36, "R8");
    for (int i = 0; i < 3; i++) issue(1, 1, 0, 1, 0, '0, '1, '0, "R8");
    seq_linear = 1;

    rd(6'h12, "R5");
    hold();
    hold();
    rd(6'h13, "R5");
    wr(6'h14, 4'h0, pat(60), "R5");
    hold();
    rd(6'h14, "R5/R9");
    idle("R5");
    rd(6'h14, "R5");

    e = model[6'h10];
    rd(6'h10, "R1");
    rd(6'h11, "R1");
    rd(6'h12, "R1");
    #1 out_en_n = 1; probe = pat(90); pen = 1;
    #1 chk(data_io === probe, "R6", data_io, probe);
    pen = 0; out_en_n = 0;
    #1 chk(data_io === e, "R6", data_io, e);

    for (int i = 0; i < 4; i++) idle("R4");
    wait (chkq.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule